// File: doc/BRIEF.md
# Sprite Attribute DMA Engine

This block copies one fixed-length page of bytes into the sprite attribute window when software writes a trigger register. The CPU-side write port is watched for a store to the trigger address. The byte written there becomes the high byte of the source address, and its low byte starts at zero. The engine then moves the bytes one at a time through its own memory master port. Each byte takes a read cycle on the source address and then a write cycle on the matching attribute address.

Reads go through the ordinary system read path, so whatever bank mapping that path applies also applies to the copied data. The read path returns data one cycle after the read is issued. While a copy runs, the engine raises a busy flag and a stall output, which keeps the CPU-side master off the bus. When the last byte has been written, the engine gives a one-cycle done pulse. A new trigger write during a copy abandons the old copy and starts again from the new page.

Top module: `sprite_dma`

## Requirements
- R1: While reset is active and in the first cycle after it, busy_o, stall_o and done_o are 0, and mem_re_o and mem_we_o are 0.
- R2: Only a write with cfg_addr_i equal to TRIG_ADDR (default 0xFF46) starts a copy. Writes to any other address leave busy_o low and cause no access on the master port.
- R3: Each byte takes two cycles. In the first, mem_re_o is 1 with the source address on mem_addr_o. In the next, mem_we_o is 1 and mem_wdata_o carries the value that mem_rdata_i returns in that cycle.
- R4: For byte i (0 to 159), the source address is the trigger byte times 256 plus i. The first read is issued in the cycle right after the trigger write is sampled.
- R5: For byte i, the destination address is 0xFE00 plus i. Exactly 160 writes are made, the last one to 0xFE9F, and busy_o is high for exactly 320 cycles per complete copy.
- R6: done_o is high for exactly one cycle, the cycle after the last write. In that cycle busy_o is already low.
- R7: A trigger write while busy_o is high restarts the copy at byte 0 of the new page. The abandoned copy produces no done pulse, and exactly one done pulse follows the restarted copy.
- R8: stall_o equals busy_o, and mem_re_o and mem_we_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | CPU-side register write strobe |
| cfg_addr_i | input | 16 | CPU-side write address |
| cfg_wdata_i | input | 8 | CPU-side write data |
| mem_re_o | output | 1 | Master read request |
| mem_we_o | output | 1 | Master write request |
| mem_addr_o | output | 16 | Master address (source on read, destination on write) |
| mem_wdata_o | output | 8 | Master write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after mem_re_o |
| busy_o | output | 1 | A copy is in progress |
| stall_o | output | 1 | Holds the CPU-side master off the bus |
| done_o | output | 1 | One-cycle pulse after the last write |

## Verification
A trigger write sampled at one rising edge produces the first read in the very next cycle. The matching write follows one cycle after each read. The done pulse appears one cycle after the write to 0xFE9F, so a full copy takes 320 busy cycles.

The bench drives its inputs 1 ns after the rising edge and samples every output on the falling edge. A monitor tracks the expected byte index from the trigger writes it sees. For each access, it compares the address and data seen at that falling edge with the value computed for that index. A done flag is armed at the last write, and the done pulse is demanded exactly one falling edge later.

// File: rtl/sprite_dma_pkg.sv
package sprite_dma_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RD   = 2'd1,
    PH_WR   = 2'd2
  } phase_e;
endpackage

// File: rtl/sprite_dma_trig.sv
module sprite_dma_trig #(
  parameter int unsigned     AW        = 16,
  parameter int unsigned     DW        = 8,
  parameter logic [AW-1:0]   TRIG_ADDR = 16'hFF46
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          start_o,
  output logic [DW-1:0] page_o
);
  logic [DW-1:0] page_q;

  assign start_o = we_i && (addr_i == TRIG_ADDR);
  assign page_o  = page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      page_q <= '0;
    else if (start_o) page_q <= wdata_i;
  end
endmodule

// File: rtl/sprite_dma_seq.sv
module sprite_dma_seq
  import sprite_dma_pkg::*;
#(
  parameter int unsigned LEN = 160,
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output phase_e        phase_o,
  output logic [CW-1:0] idx_o,
  output logic          done_o
);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  phase_e        phase_q;
  logic [CW-1:0] idx_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        // restart wins over any step in flight
        phase_q <= PH_RD;
        idx_q   <= '0;
      end else begin
        unique case (phase_q)
          PH_RD: phase_q <= PH_WR;
          PH_WR: begin
            if (idx_q == LAST) begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end else begin
              phase_q <= PH_RD;
              idx_q   <= idx_q + 1'b1;
            end
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign done_o  = done_q;
endmodule

// File: rtl/sprite_dma_agen.sv
module sprite_dma_agen
  import sprite_dma_pkg::*;
#(
  parameter int unsigned   AW       = 16,
  parameter int unsigned   DW       = 8,
  parameter int unsigned   CW       = 8,
  parameter logic [AW-1:0] DST_BASE = 16'hFE00
) (
  input  phase_e        phase_i,
  input  logic [DW-1:0] page_i,
  input  logic [CW-1:0] idx_i,
  output logic          re_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned LOW_W = AW - DW;

  logic [AW-1:0] src_base;
  logic [AW-1:0] src_addr;
  logic [AW-1:0] dst_addr;

  assign src_base = {page_i, {LOW_W{1'b0}}};
  assign src_addr = src_base + AW'(idx_i);
  assign dst_addr = DST_BASE + AW'(idx_i);

  always_comb begin
    re_o   = 1'b0;
    we_o   = 1'b0;
    addr_o = '0;
    unique case (phase_i)
      PH_RD: begin re_o = 1'b1; addr_o = src_addr; end
      PH_WR: begin we_o = 1'b1; addr_o = dst_addr; end
      default: ;
    endcase
  end
endmodule

// File: rtl/sprite_dma.sv
module sprite_dma
  import sprite_dma_pkg::*;
#(
  parameter int unsigned   AW        = 16,
  parameter int unsigned   DW        = 8,
  parameter int unsigned   LEN       = 160,
  parameter logic [AW-1:0] TRIG_ADDR = 16'hFF46,
  parameter logic [AW-1:0] DST_BASE  = 16'hFE00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [DW-1:0] cfg_wdata_i,
  output logic          mem_re_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          stall_o,
  output logic          done_o
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic          start;
  logic [DW-1:0] page;
  phase_e        phase;
  logic [CW-1:0] idx;

  sprite_dma_trig #(.AW(AW), .DW(DW), .TRIG_ADDR(TRIG_ADDR)) u_trig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .start_o (start),
    .page_o  (page)
  );

  sprite_dma_seq #(.LEN(LEN)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .phase_o (phase),
    .idx_o   (idx),
    .done_o  (done_o)
  );

  sprite_dma_agen #(.AW(AW), .DW(DW), .CW(CW), .DST_BASE(DST_BASE)) u_agen (
    .phase_i (phase),
    .page_i  (page),
    .idx_i   (idx),
    .re_o    (mem_re_o),
    .we_o    (mem_we_o),
    .addr_o  (mem_addr_o)
  );

  // read data returns in the write cycle; forward it straight through
  assign mem_wdata_o = mem_we_o ? mem_rdata_i : '0;
  assign busy_o      = (phase != PH_IDLE);
  assign stall_o     = busy_o;
endmodule

// File: rtl/sprite_dma_chk.sv
module sprite_dma_chk #(
  parameter int unsigned   AW        = 16,
  parameter int unsigned   DW        = 8,
  parameter int unsigned   LEN       = 160,
  parameter logic [AW-1:0] TRIG_ADDR = 16'hFF46,
  parameter logic [AW-1:0] DST_BASE  = 16'hFE00
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic [AW-1:0] cfg_addr_i,
  input logic [DW-1:0] cfg_wdata_i,
  input logic          mem_re_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          busy_o,
  input logic          stall_o,
  input logic          done_o
);
  logic          trig;
  logic [AW-1:0] page_base;
  assign trig      = cfg_we_i && (cfg_addr_i == TRIG_ADDR);
  assign page_base = {cfg_wdata_i, {(AW-DW){1'b0}}};

  a_r1_idle_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> !busy_o && !mem_re_o && !mem_we_o && !done_o);

  a_r4_first_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> mem_re_o && (mem_addr_o == $past(page_base)));

  a_r3_read_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o && !trig |=> mem_we_o);

  a_r5_dst_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o >= DST_BASE) && (mem_addr_o < DST_BASE + AW'(LEN)));

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(mem_we_o));

  a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));

  a_r8_stall_on_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o || mem_we_o) |-> stall_o);
endmodule

bind sprite_dma sprite_dma_chk #(
  .AW(AW), .DW(DW), .LEN(LEN), .TRIG_ADDR(TRIG_ADDR), .DST_BASE(DST_BASE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_wdata_i (cfg_wdata_i),
  .mem_re_o    (mem_re_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .busy_o      (busy_o),
  .stall_o     (stall_o),
  .done_o      (done_o)
);

// File: tb/sprite_dma_test.sv
`timescale 1ns/1ps
module sprite_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        re, we, busy, stall, done;
  logic [15:0] maddr;
  logic [7:0]  wdata;
  logic [7:0]  rdata = '0;

  int tests = 0, fails = 0;
  int wr_cnt, rd_cnt, busy_cyc, done_cnt, done_err, mon_err, excl_err;
  int mon_idx = 0;
  logic [7:0] mon_page = '0;
  bit done_exp = 0;

  always #2.5 clk = ~clk;

  sprite_dma uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .mem_re_o(re), .mem_we_o(we), .mem_addr_o(maddr),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata), .busy_o(busy), .stall_o(stall),
    .done_o(done)
  );

  function automatic logic [7:0] src_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // synchronous read path: data is valid the cycle after the read
  always @(posedge clk) if (re) rdata <= src_val(maddr);

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_exp) begin
        if (!(done && !busy)) done_err++;
        done_exp = 0;
      end else if (done) done_err++;
      if (done) done_cnt++;
      if (busy) busy_cyc++;
      if ((stall != busy) || (re && we)) excl_err++;
      if (re) begin
        rd_cnt++;
        if (maddr != ({mon_page, 8'h00} + 16'(mon_idx))) mon_err++;
      end
      if (we) begin
        wr_cnt++;
        if (maddr != 16'hFE00 + 16'(mon_idx) ||
            wdata != src_val({mon_page, 8'h00} + 16'(mon_idx))) mon_err++;
        if (mon_idx == 159) done_exp = 1;
        mon_idx++;
      end
      if (cfg_we && cfg_addr == 16'hFF46) begin
        mon_page = cfg_wdata;
        mon_idx  = 0;
        done_exp = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_stats();
    wr_cnt = 0; rd_cnt = 0; busy_cyc = 0; done_cnt = 0;
    done_err = 0; mon_err = 0; excl_err = 0;
  endtask

  task automatic cfg_write(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (done_cnt == 0 && n < 2000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!busy && !stall && !done && !re && !we, "R1 outputs in reset", {busy, re, we, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !stall && !done && !re && !we, "R1 outputs after reset", {busy, re, we, done}, 0);
  endtask

  task automatic t_ignore();
    clr_stats();
    cfg_write(16'hFF45, 8'h33);
    cfg_write(16'hFE46, 8'hC0);
    cfg_write(16'hFF47, 8'h12);
    repeat (10) @(negedge clk);
    check(busy_cyc == 0, "R2 busy on non-trigger write", busy_cyc, 0);
    check(rd_cnt + wr_cnt == 0, "R2 master accesses on non-trigger write", rd_cnt + wr_cnt, 0);
  endtask

  task automatic t_full(input logic [7:0] page);
    clr_stats();
    cfg_write(16'hFF46, page);
    wait_done();
    check(rd_cnt == 160, "R4 read count", rd_cnt, 160);
    check(mon_err == 0, "R3/R4 address or data mismatches", mon_err, 0);
    check(wr_cnt == 160, "R5 write count", wr_cnt, 160);
    check(busy_cyc == 320, "R5 busy cycles", busy_cyc, 320);
    check(done_cnt == 1, "R6 done pulses", done_cnt, 1);
    check(done_err == 0, "R6 done timing errors", done_err, 0);
    check(excl_err == 0, "R8 stall/exclusivity errors", excl_err, 0);
  endtask

  task automatic t_restart();
    clr_stats();
    cfg_write(16'hFF46, 8'h12);
    repeat (41) @(posedge clk);
    cfg_write(16'hFF46, 8'h40);
    wait_done();
    check(done_cnt == 1, "R7 single done after restart", done_cnt, 1);
    check(done_err == 0, "R7 done timing after restart", done_err, 0);
    check(mon_err == 0, "R7 restarted copy mismatches", mon_err, 0);
    check(wr_cnt > 160 && wr_cnt < 320, "R7 aborted plus full writes", wr_cnt, 180);
    check(busy_cyc > 320, "R7 busy spans both copies", busy_cyc, 360);
    check(excl_err == 0, "R8 stall/exclusivity during restart", excl_err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog (R1..) actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    clr_stats();
    repeat (3) @(posedge clk);
    t_reset();
    t_ignore();
    t_full(8'h00);
    t_full(8'hC1);
    t_full(8'hFF);
    t_restart();
    t_full(8'h7E);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule